// File: doc/BRIEF.md
# Page-Buffered Host Window to SDRAM

This block gives a host processor programmed-I/O access to SDRAM one page at a time. A page is 512 bytes: 128 words of 32 bits, or 256 words of 16 bits in SDRAM terms. The host loads a start address in 16-bit word units together with a direction. The low eight address bits are dropped, so every page starts on a 256-word boundary. The host then raises the channel enable. In read mode the block fills its page buffer from memory and raises a ready flag. The host drains the buffer through one window read port. In write mode the host fills the buffer through a window write port. A next-page strobe then commits the buffer to memory and moves the address on by 256.

Window reads are pipelined by one access. Each read strobe returns the word that the previous access prefetched, then prefetches the word at the current buffer index and steps the index. The first read of every page therefore returns stale data, and a full page takes 129 reads. A separate write-empty flag is low while a committed page is still being written to memory. When the channel enable is low, no further page is prefetched. The page address still advances, so raising the enable again resumes at the following page. The memory side is a simple request/acknowledge port. The block holds one 32-bit beat on the port until it is acknowledged. Beat k of a page uses address base + 2k.

The controller has five states:
- IDLE: no transfer.
- FETCH: page being read from memory.
- RD_READY: buffer full, host draining it.
- WR_READY: buffer free, host filling it.
- FLUSH: buffer being written to memory.

Transitions:
- IDLE→FETCH: enable high in read mode.
- IDLE→WR_READY: enable high in write mode.
- FETCH→RD_READY: the 128th beat is acknowledged.
- RD_READY→FETCH: next-page strobe with the enable high.
- RD_READY→IDLE: next-page strobe with the enable low.
- WR_READY→FLUSH: next-page strobe.
- FLUSH→WR_READY: the 128th beat is acknowledged with the enable high.
- FLUSH→IDLE: the 128th beat is acknowledged with the enable low.
- any state→IDLE: a configuration load.

Top module: `sdram_page_window`

## Requirements
- R1: After reset page_rdy is 0, wr_empty is 1, mem_req is 0 and win_rdata is 0.
- R2: A configuration load clears address bits 7:0. In read mode, enabling the channel issues 128 read beats. Beat k uses mem_addr = base + 2k. mem_req, mem_addr and mem_we hold steady until mem_ack.
- R3: In read mode, page_rdy rises after the 128th read beat is acknowledged. Buffer word k then holds the mem_rdata of beat k.
- R4: A win_rd strobe while page_rdy is high in read mode returns on win_rdata the value prefetched by the previous access. It then loads buffer word [index] and increments the index. The first read of a page returns the previous win_rdata. Read k+1 (k = 0..127) returns word k.
- R5: In read mode, a page_next strobe drops page_rdy in the next cycle. With the enable high, it starts fetching the page at base + 256.
- R6: A page_next strobe with chan_en low causes no memory request, and page_rdy stays low. Raising chan_en later fetches the page at the advanced address.
- R7: In write mode, enabling the channel raises page_rdy with no memory traffic. Successive win_wr strobes store win_wdata at buffer words 0, 1, 2, … in order.
- R8: In write mode, page_next drops wr_empty and page_rdy in the next cycle. The block then issues 128 write beats, with word k at base + 2k. After the last acknowledge wr_empty returns to 1 and page_rdy returns to 1 if enabled. page_rdy and a low wr_empty never coincide.
- R9: win_wr in read mode and win_rd in write mode are ignored. They change neither the buffer, the buffer index nor win_rdata.
- R10: The page address wraps from the top of the 2^25-word space to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load start address and direction; aborts any transfer |
| cfg_base | input | 25 | Start address in 16-bit words (bits 7:0 ignored) |
| cfg_write | input | 1 | Direction: 1 write, 0 read |
| chan_en | input | 1 | Channel enable; low stops prefetching further pages |
| page_next | input | 1 | Next-page strobe |
| win_rd | input | 1 | Window read strobe |
| win_rdata | output | 32 | Window read data (pipelined by one access) |
| win_wr | input | 1 | Window write strobe |
| win_wdata | input | 32 | Window write data |
| page_rdy | output | 1 | Buffer accessible by host |
| wr_empty | output | 1 | Previous written page fully transferred |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 25 | Memory beat address in 16-bit words |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory beat acknowledge |

## Verification
The bench targets the stale first read of each page. A design without the one-access pipeline would shift every word by one, or would return word 0 where the previous value is expected. It checks that page_next advances the address by exactly 256 and wraps at the top of the space. A wrong increment or a missing wrap shows up as a wrong first mem_addr. It also checks that a strobe with the enable low leaves the memory port silent. A design that ignored the enable would start a fetch on its own. Finally it drives window accesses of the wrong direction. A design that accepted them would corrupt the buffer or shift the index, so the following page read or write would be off.

// File: rtl/spw_pkg.sv
package spw_pkg;

    // Channel controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RD_READY,
        ST_WR_READY,
        ST_FLUSH
    } chan_state_t;

    localparam int WORD_W = 32;

endpackage

// File: rtl/spw_page_buf.sv
module spw_page_buf #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_host,
    output logic [DATA_W-1:0] rdata_host,
    input  logic [IDX_W-1:0]  raddr_mem,
    output logic [DATA_W-1:0] rdata_mem
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata_host = store[raddr_host];
    assign rdata_mem  = store[raddr_mem];

endmodule

// File: rtl/spw_page_addr.sv
module spw_page_addr #(
    parameter int ADDR_W = 25,
    parameter int PAGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-PAGE_W-1:0] load_page,
    input  logic                     advance,
    output logic [ADDR_W-1:0]        page_base
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [HI_W-1:0] page_num;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_num <= '0;
        end else if (load) begin
            page_num <= load_page;
        end else if (advance) begin
            page_num <= page_num + 1'b1;
        end
    end

    assign page_base = {page_num, {PAGE_W{1'b0}}};

    // R10
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && page_base == {ADDR_W{1'b1}} - ((1 << PAGE_W) - 1))
        |=> (page_base == '0));

endmodule

// File: rtl/spw_chan_fsm.sv
module spw_chan_fsm #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_write,
    input  logic             chan_en,
    input  logic             page_next,
    input  logic             win_rd,
    input  logic             win_wr,
    input  logic             mem_ack,
    output logic [IDX_W-1:0] beat_idx,
    output logic [IDX_W-1:0] host_idx,
    output logic             page_adv,
    output logic             fetch_we,
    output logic             host_wr_ok,
    output logic             host_rd_ok,
    output logic             mem_req,
    output logic             mem_we,
    output logic             page_rdy,
    output logic             wr_empty
);
    import spw_pkg::*;

    localparam logic [IDX_W-1:0] LAST_BEAT = '1;

    chan_state_t state, state_nx;
    logic        dir_write;
    logic        last_ack;
    logic        enter_ready;

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_write <= 1'b0;
        end else if (cfg_load) begin
            dir_write <= cfg_write;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign last_ack = mem_ack && (beat_idx == LAST_BEAT);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (chan_en) begin
                    state_nx = dir_write ? ST_WR_READY : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (last_ack) begin
                    state_nx = ST_RD_READY;
                end
            end
            ST_RD_READY: begin
                if (page_next) begin
                    state_nx = chan_en ? ST_FETCH : ST_IDLE;
                end
            end
            ST_WR_READY: begin
                if (page_next) begin
                    state_nx = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (last_ack) begin
                    state_nx = chan_en ? ST_WR_READY : ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        if (cfg_load) begin
            state_nx = ST_IDLE;
        end
    end

    // Output decode
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        page_rdy   = 1'b0;
        wr_empty   = 1'b1;
        fetch_we   = 1'b0;
        host_wr_ok = 1'b0;
        host_rd_ok = 1'b0;
        page_adv   = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                fetch_we = mem_ack;
            end
            ST_RD_READY: begin
                page_rdy   = 1'b1;
                host_rd_ok = win_rd;
                page_adv   = page_next && !cfg_load;
            end
            ST_WR_READY: begin
                page_rdy   = 1'b1;
                host_wr_ok = win_wr;
            end
            ST_FLUSH: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                wr_empty = 1'b0;
                page_adv = last_ack && !cfg_load;
            end
            default: begin
            end
        endcase
    end

    assign enter_ready = (state_nx != state) &&
                         ((state_nx == ST_RD_READY) || (state_nx == ST_WR_READY));

    // Beat and host index counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_idx <= '0;
            host_idx <= '0;
        end else if (cfg_load) begin
            beat_idx <= '0;
            host_idx <= '0;
        end else begin
            if (mem_req && mem_ack) begin
                beat_idx <= beat_idx + 1'b1;
            end
            if (enter_ready) begin
                host_idx <= '0;
            end else if (host_rd_ok || host_wr_ok) begin
                host_idx <= host_idx + 1'b1;
            end
        end
    end

    // R3
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && last_ack && !cfg_load) |=> page_rdy);

    // R8
    flush_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_empty) |-> $past(page_next));

    // R6
    idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !mem_req && state != ST_WR_READY) |=> !mem_req);

    // R9
    wrong_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_READY && !win_wr && !cfg_load && !page_next) |=> $stable(host_idx));

endmodule

// File: rtl/sdram_page_window.sv
module sdram_page_window #(
    parameter int ROW_W  = 12,
    parameter int SEG_W  = 5,
    parameter int PAGE_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_load,
    input  logic [ROW_W+SEG_W+PAGE_W-1:0]   cfg_base,
    input  logic                            cfg_write,
    input  logic                            chan_en,
    input  logic                            page_next,
    input  logic                            win_rd,
    output logic [31:0]                     win_rdata,
    input  logic                            win_wr,
    input  logic [31:0]                     win_wdata,
    output logic                            page_rdy,
    output logic                            wr_empty,
    output logic                            mem_req,
    output logic                            mem_we,
    output logic [ROW_W+SEG_W+PAGE_W-1:0]   mem_addr,
    output logic [31:0]                     mem_wdata,
    input  logic [31:0]                     mem_rdata,
    input  logic                            mem_ack
);
    import spw_pkg::*;

    localparam int ADDR_W = ROW_W + SEG_W + PAGE_W;
    localparam int IDX_W  = PAGE_W - 1;

    logic [IDX_W-1:0]  beat_idx;
    logic [IDX_W-1:0]  host_idx;
    logic              page_adv;
    logic              fetch_we;
    logic              host_wr_ok;
    logic              host_rd_ok;
    logic [ADDR_W-1:0] page_base;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_waddr;
    logic [WORD_W-1:0] buf_wdata;
    logic [WORD_W-1:0] host_word;
    logic              unused_low_bits;

    assign unused_low_bits = ^cfg_base[PAGE_W-1:0];

    spw_chan_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_write  (cfg_write),
        .chan_en    (chan_en),
        .page_next  (page_next),
        .win_rd     (win_rd),
        .win_wr     (win_wr),
        .mem_ack    (mem_ack),
        .beat_idx   (beat_idx),
        .host_idx   (host_idx),
        .page_adv   (page_adv),
        .fetch_we   (fetch_we),
        .host_wr_ok (host_wr_ok),
        .host_rd_ok (host_rd_ok),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .page_rdy   (page_rdy),
        .wr_empty   (wr_empty)
    );

    spw_page_addr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .load_page (cfg_base[ADDR_W-1:PAGE_W]),
        .advance   (page_adv),
        .page_base (page_base)
    );

    assign buf_we    = fetch_we || host_wr_ok;
    assign buf_waddr = fetch_we ? beat_idx : host_idx;
    assign buf_wdata = fetch_we ? mem_rdata : win_wdata;

    spw_page_buf #(
        .IDX_W  (IDX_W),
        .DATA_W (WORD_W)
    ) u_buf (
        .clk        (clk),
        .we         (buf_we),
        .waddr      (buf_waddr),
        .wdata      (buf_wdata),
        .raddr_host (host_idx),
        .rdata_host (host_word),
        .raddr_mem  (beat_idx),
        .rdata_mem  (mem_wdata)
    );

    // One-access read pipeline: the strobe returns the held word, then prefetches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_rdata <= '0;
        end else if (host_rd_ok) begin
            win_rdata <= host_word;
        end
    end

    assign mem_addr = {page_base[ADDR_W-1:PAGE_W], beat_idx, 1'b0};

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_load)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    rdy_vs_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_rdy && !wr_empty));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && wr_empty && !page_rdy));

endmodule

// File: tb/sdram_page_window_test.sv
`timescale 1ns/1ps
module sdram_page_window_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load, cfg_write, chan_en, page_next;
    logic [24:0] cfg_base;
    logic        win_rd, win_wr;
    logic [31:0] win_rdata, win_wdata;
    logic        page_rdy, wr_empty, mem_req, mem_we;
    logic [24:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ack;

    int tests = 0;
    int fails = 0;
    int wcnt  = 0;
    logic [31:0] wlog_d [128];
    logic [24:0] wlog_a [128];
    logic [31:0] model_rd = '0;

    // bit 25 = direction (1 write), bits 24:0 = raw start address
    localparam logic [25:0] VEC [4] = '{
        26'h00001A5,
        26'h2012300,
        26'h1FFFF00,
        26'h3FFFFFF
    };

    always #2 clk = ~clk;

    sdram_page_window uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_write(cfg_write), .chan_en(chan_en), .page_next(page_next),
        .win_rd(win_rd), .win_rdata(win_rdata), .win_wr(win_wr),
        .win_wdata(win_wdata), .page_rdy(page_rdy), .wr_empty(wr_empty),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] pat(input logic [24:0] a);
        return ({7'd0, a} * 32'd40503) ^ 32'h6C8E9CF5;
    endfunction

    function automatic logic [31:0] wpat(input int v, input int k);
        return 32'hA0000000 + (v << 16) + k;
    endfunction

    // Memory model: one beat acknowledged every other cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= pat(mem_addr);
            if (mem_req && mem_we && mem_ack) begin
                wlog_d[mem_addr[7:1]] <= mem_wdata;
                wlog_a[mem_addr[7:1]] <= mem_addr;
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [24:0] a, input logic w);
        cfg_load = 1'b1; cfg_base = a; cfg_write = w;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_rdy();
        for (int n = 0; n < 3000 && !page_rdy; n++) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int n = 0; n < 3000 && !mem_req; n++) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int n = 0; n < 3000 && !wr_empty; n++) @(negedge clk);
    endtask

    task automatic pulse_next();
        page_next = 1'b1;
        @(negedge clk);
        page_next = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] d);
        win_rd = 1'b1;
        d = win_rdata;
        @(negedge clk);
        win_rd = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] d);
        win_wr = 1'b1; win_wdata = d;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    // R4 stale first read, R3 page contents
    task automatic read_page(input logic [24:0] base, input string tag);
        logic [31:0] d, bad_a, bad_e;
        int bad = 0;
        rd_word(d);
        check(d == model_rd, {"R4 stale first read ", tag}, d, model_rd);
        bad_a = '0; bad_e = '0;
        for (int k = 0; k < 128; k++) begin
            rd_word(d);
            if (d != pat(base + 25'(2 * k))) begin
                if (bad == 0) begin bad_a = d; bad_e = pat(base + 25'(2 * k)); end
                bad++;
            end
        end
        check(bad == 0, {"R3 R4 page words ", tag}, bad_a, bad_e);
        model_rd = pat(base);
    endtask

    // R7 fill, R8 flush
    task automatic write_page(input logic [24:0] base, input int v);
        int c0, bad;
        logic [31:0] bad_a, bad_e;
        check(page_rdy && !mem_req, "R7 write ready without traffic", {30'd0, page_rdy, mem_req}, 32'd2);
        for (int k = 0; k < 128; k++) wr_word(wpat(v, k));
        c0 = wcnt;
        pulse_next();
        check(!wr_empty && !page_rdy, "R8 flush start flags", {30'd0, wr_empty, page_rdy}, 32'd0);
        wait_empty();
        check(wcnt - c0 == 128, "R8 write beat count", wcnt - c0, 32'd128);
        bad = 0; bad_a = '0; bad_e = '0;
        for (int k = 0; k < 128; k++) begin
            if (wlog_d[k] != wpat(v, k) || wlog_a[k] != base + 25'(2 * k)) begin
                if (bad == 0) begin bad_a = wlog_d[k]; bad_e = wpat(v, k); end
                bad++;
            end
        end
        check(bad == 0, "R7 R8 written words and addresses", bad_a, bad_e);
        @(negedge clk);
        check(page_rdy && wr_empty, "R8 ready after flush", {30'd0, page_rdy, wr_empty}, 32'd3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [24:0] base, nxt;
        logic [31:0] snap, d;
        int seen;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_base = '0; cfg_write = 1'b0;
        chan_en = 1'b0; page_next = 1'b0; win_rd = 1'b0; win_wr = 1'b0; win_wdata = '0;
        repeat (3) @(negedge clk);
        // R1
        check(!page_rdy && wr_empty && !mem_req && win_rdata == 0, "R1 reset state",
              {28'd0, page_rdy, wr_empty, mem_req, |win_rdata}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < 4; v++) begin
            base = {VEC[v][24:8], 8'h00};
            chan_en = 1'b0;
            do_cfg(VEC[v][24:0], VEC[v][25]);
            chan_en = 1'b1;
            if (!VEC[v][25]) begin
                wait_req();
                check(mem_addr == base && !mem_we, "R2 first fetch address aligned", 32'(mem_addr), 32'(base));
                wait_rdy();
                check(page_rdy, "R3 ready after fetch", {31'd0, page_rdy}, 32'd1);
                read_page(base, "table");
                pulse_next();
                check(!page_rdy, "R5 ready drops on strobe", {31'd0, page_rdy}, 32'd0);
                wait_req();
                nxt = base + 25'd256;
                check(mem_addr == nxt, "R5 R10 next page address", 32'(mem_addr), 32'(nxt));
                wait_rdy();
                read_page(nxt, "table next");
            end else begin
                wait_rdy();
                write_page(base, v);
            end
            chan_en = 1'b0;
        end

        // R6: strobe with channel disabled
        do_cfg(25'h0004000, 1'b0);
        chan_en = 1'b1;
        wait_rdy();
        read_page(25'h0004000, "R6 setup");
        chan_en = 1'b0;
        pulse_next();
        seen = 0;
        for (int n = 0; n < 20; n++) begin
            if (mem_req || page_rdy) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R6 no fetch while disabled", seen, 0);
        chan_en = 1'b1;
        wait_req();
        check(mem_addr == 25'h0004100, "R6 resume at advanced address", 32'(mem_addr), 32'h4100);
        wait_rdy();
        read_page(25'h0004100, "R6 resumed");
        chan_en = 1'b0;

        // R9: window reads ignored in write mode
        do_cfg(25'h0008000, 1'b1);
        chan_en = 1'b1;
        wait_rdy();
        snap = win_rdata;
        for (int n = 0; n < 3; n++) rd_word(d);
        check(win_rdata == snap, "R9 read ignored in write mode", win_rdata, snap);
        write_page(25'h0008000, 7);
        chan_en = 1'b0;

        // R9: window writes ignored in read mode
        do_cfg(25'h0008000, 1'b0);
        chan_en = 1'b1;
        wait_rdy();
        wr_word(32'hDEADBEEF);
        wr_word(32'hDEADBEEF);
        read_page(25'h0008000, "R9 writes ignored in read mode");
        chan_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule